// File: doc/BRIEF.md
# Quad-Channel Serial Converter Register Front-End

This block is the digital control core of a four-channel, 12-bit converter whose codes arrive over a serial link. A 16-bit shift register is stepped by the rising edges of the OR of the active-low select and the serial clock. Each word carries a 2-bit channel address in its top bits, two ignored bits, and a 12-bit code sent most significant bit first. The address picks one of four input registers. That register follows the code field of the shift register while the load pin is low. Four output registers follow their input registers while the transfer pin is low, so a new set of codes can be staged on every channel and then moved to all outputs at once.

All pins are brought into a fast system-clock domain through two-flop synchronizers. The level-sensitive "open while low" behaviour is therefore modelled with ordinary flip-flops, and a pin change takes effect within four system clocks. An asynchronous reset input forces every input and output register to zero-scale or mid-scale, chosen by a level pin. Reset leaves the shift register alone. The four output codes go to the analog side on one flat bus, and a one-cycle strobe marks every change of an output code made by a transfer.

Top module: `qdac_frontend`

## Requirements
- R1: A word is 16 bits. After 16 shift steps, the first two bits shifted form the channel address (first bit is the address MSB), the next two have no effect, and the last twelve form the code, MSB first. Address 0 selects channel 0 (`dacCode[11:0]`), 1 selects channel 1 (`[23:12]`), 2 selects channel 2 (`[35:24]`), and 3 selects channel 3 (`[47:36]`).
- R2: The shift register advances exactly one bit on each rising edge of (`csN` OR `sclk`). Toggling `sclk` while `csN` is high leaves it unchanged.
- R3: If `csN` rises while `sclk` is low, the register shifts one extra bit, taking the value on `sdi` at that moment.
- R4: While `loadRegN` is low, the addressed input register follows the code field. While `loadRegN` is high, all input registers hold. Input registers that are not addressed always hold, so loading alone never changes `dacCode`.
- R5: While `ldacN` is low, all four output registers follow their input registers, and they change in the same cycle. While `ldacN` is high, they hold.
- R6: While `resetN` is low, every input and output register is forced, without waiting for a clock, to 0x000 if `resetSel` is low or 0x800 if `resetSel` is high.
- R7: Reset does not change the shift register. After reset, a load and a transfer deliver the word that was shifted in before the reset.
- R8: When `resetN` returns high, registers that are held keep the reset code. An input register that is open at that moment (loadRegN low) takes the shift register's code field.
- R9: Bits shifted while `loadRegN` is low change each input register the moving address field selects, and each such register keeps the code field it saw last.
- R10: `updateStrobe` is high for one cycle in each cycle where a transfer changes at least one output code. It stays low when a transfer changes nothing and while `resetN` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all pins |
| resetN | input | 1 | Asynchronous reset, active low |
| resetSel | input | 1 | Reset code select: low gives zero-scale, high gives mid-scale |
| csN | input | 1 | Serial select, active low, ORed with sclk |
| sclk | input | 1 | Serial clock |
| sdi | input | 1 | Serial data |
| loadRegN | input | 1 | Opens the addressed input register while low |
| ldacN | input | 1 | Opens all output registers while low |
| dacCode | output | 48 | Four 12-bit output codes, channel 0 in the low bits |
| updateStrobe | output | 1 | One-cycle pulse on an output code change |

## Verification
Two functions can act in the same cycle. Shifting can overlap an open input register, and a reset release can coincide with an open load pin. The bench provokes the first by holding `loadRegN` and `ldacN` low for a whole word. It provokes the second by dropping `loadRegN` during reset. A bench-side model of the shift register replays every rising edge of the ORed serial clock and updates whichever register the moving address selects, and the outputs are compared with that model after each step. The extra edge from a select rising while the clock is low is judged the same way.

// File: rtl/qdac_pkg.sv
package qdac_pkg;
  // strobes from pin handling to the register datapath
  typedef struct packed {
    logic shiftStep;   // one shift of the serial register this cycle
    logic serialBit;   // synchronized serial data
    logic loadOpen;    // addressed input register follows the code field
    logic xferOpen;    // output registers follow input registers
  } qdacCtl_t;
endpackage

// File: rtl/qdac_ctrl.sv
module qdac_ctrl
  import qdac_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic     clk,
  input  logic     resetN,
  input  logic     csN,
  input  logic     sclk,
  input  logic     sdi,
  input  logic     loadRegN,
  input  logic     ldacN,
  output qdacCtl_t ctl
);
  localparam int PIN_COUNT = 5;
  localparam int LAST = SYNC_STAGES - 1;

  logic [PIN_COUNT-1:0] pinVec;
  logic [PIN_COUNT-1:0] syncStage [SYNC_STAGES];
  logic orNow, orPrev;

  assign pinVec = {csN, sclk, sdi, loadRegN, ldacN};

  // idle-high reset on every stage: no false rising edge after reset
  always_ff @(posedge clk or negedge resetN) begin
    if (!resetN) syncStage[0] <= '1;
    else         syncStage[0] <= pinVec;
  end

  for (genvar s = 1; s < SYNC_STAGES; s++) begin : g_sync
    always_ff @(posedge clk or negedge resetN) begin
      if (!resetN) syncStage[s] <= '1;
      else         syncStage[s] <= syncStage[s-1];
    end
  end

  assign orNow = syncStage[LAST][4] | syncStage[LAST][3];

  always_ff @(posedge clk or negedge resetN) begin
    if (!resetN) orPrev <= 1'b1;
    else         orPrev <= orNow;
  end

  assign ctl.shiftStep = orNow & ~orPrev;
  assign ctl.serialBit = syncStage[LAST][2];
  assign ctl.loadOpen  = ~syncStage[LAST][1];
  assign ctl.xferOpen  = ~syncStage[LAST][0];
endmodule

// File: rtl/qdac_datapath.sv
module qdac_datapath
  import qdac_pkg::*;
#(
  parameter int CODE_W   = 12,
  parameter int CHANNELS = 4,
  parameter int PAD_W    = 2
) (
  input  logic                       clk,
  input  logic                       resetN,
  input  logic                       resetSel,
  input  qdacCtl_t                   ctl,
  output logic [CHANNELS*CODE_W-1:0] dacCode,
  output logic                       updateStrobe
);
  localparam int ADDR_W = $clog2(CHANNELS);
  localparam int WORD_W = ADDR_W + PAD_W + CODE_W;
  localparam logic [CODE_W-1:0] MID_CODE = {1'b1, {(CODE_W-1){1'b0}}};

  logic [WORD_W-1:0]   shiftReg;
  logic [ADDR_W-1:0]   addrField;
  logic [CODE_W-1:0]   codeField;
  logic [CODE_W-1:0]   resetCode;
  logic [CHANNELS-1:0] diffBits;

  // serial register is untouched by reset
  always_ff @(posedge clk) begin
    if (ctl.shiftStep) shiftReg <= {shiftReg[WORD_W-2:0], ctl.serialBit};
  end

  assign addrField = shiftReg[WORD_W-1 -: ADDR_W];
  assign codeField = shiftReg[CODE_W-1:0];
  assign resetCode = resetSel ? MID_CODE : '0;

  for (genvar ch = 0; ch < CHANNELS; ch++) begin : g_chan
    logic [CODE_W-1:0] inReg;
    logic [CODE_W-1:0] outReg;

    always_ff @(posedge clk or negedge resetN) begin
      if (!resetN)
        inReg <= resetCode;
      else if (ctl.loadOpen && (addrField == ADDR_W'(ch)))
        inReg <= codeField;
    end

    always_ff @(posedge clk or negedge resetN) begin
      if (!resetN)           outReg <= resetCode;
      else if (ctl.xferOpen) outReg <= inReg;
    end

    assign diffBits[ch] = ctl.xferOpen && (inReg != outReg);
    assign dacCode[ch*CODE_W +: CODE_W] = outReg;
  end

  always_ff @(posedge clk or negedge resetN) begin
    if (!resetN) updateStrobe <= 1'b0;
    else         updateStrobe <= |diffBits;
  end
endmodule

// File: rtl/qdac_frontend.sv
module qdac_frontend
  import qdac_pkg::*;
#(
  parameter int CODE_W      = 12,
  parameter int CHANNELS    = 4,
  parameter int PAD_W       = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic                       clk,
  input  logic                       resetN,
  input  logic                       resetSel,
  input  logic                       csN,
  input  logic                       sclk,
  input  logic                       sdi,
  input  logic                       loadRegN,
  input  logic                       ldacN,
  output logic [CHANNELS*CODE_W-1:0] dacCode,
  output logic                       updateStrobe
);
  qdacCtl_t ctl;

  qdac_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .resetN(resetN), .csN(csN), .sclk(sclk), .sdi(sdi),
    .loadRegN(loadRegN), .ldacN(ldacN), .ctl(ctl)
  );

  qdac_datapath #(.CODE_W(CODE_W), .CHANNELS(CHANNELS), .PAD_W(PAD_W)) u_dp (
    .clk(clk), .resetN(resetN), .resetSel(resetSel), .ctl(ctl),
    .dacCode(dacCode), .updateStrobe(updateStrobe)
  );
endmodule

// File: rtl/qdac_checker.sv
module qdac_checker #(
  parameter int CODE_W      = 12,
  parameter int CHANNELS    = 4,
  parameter int SYNC_STAGES = 2
) (
  input logic                       clk,
  input logic                       resetN,
  input logic                       resetSel,
  input logic                       ldacN,
  input logic [CHANNELS*CODE_W-1:0] dacCode,
  input logic                       updateStrobe
);
  localparam logic [CODE_W-1:0] MID_CODE = {1'b1, {(CODE_W-1){1'b0}}};
  localparam int RUN_MAX = 15;

  logic [3:0] ldacHighRun;

  always_ff @(posedge clk or negedge resetN) begin
    if (!resetN)        ldacHighRun <= '0;
    else if (!ldacN)    ldacHighRun <= '0;
    else if (ldacHighRun != 4'(RUN_MAX)) ldacHighRun <= ldacHighRun + 4'd1;
  end

  // R6: held reset shows the selected code on every channel
  a_r6_reset_code: assert property (@(posedge clk)
    (!resetN && !$past(resetN) && $stable(resetSel)) |->
      dacCode == {CHANNELS{resetSel ? MID_CODE : {CODE_W{1'b0}}}});

  // R10: strobe quiet while in reset
  a_r10_quiet_in_reset: assert property (@(posedge clk)
    !resetN |-> !updateStrobe);

  // R10: a strobe cycle shows a new output value
  a_r10_strobe_marks_change: assert property (@(posedge clk) disable iff (!resetN)
    updateStrobe |-> dacCode != $past(dacCode));

  // R10: every output change outside reset carries a strobe
  a_r10_change_needs_strobe: assert property (@(posedge clk) disable iff (!resetN)
    ($past(resetN) && dacCode != $past(dacCode)) |-> updateStrobe);

  // R5: outputs hold once the transfer pin has been high long enough
  a_r5_latched_hold: assert property (@(posedge clk) disable iff (!resetN)
    ($past(resetN) && ldacHighRun > 4'(SYNC_STAGES)) |-> $stable(dacCode));
endmodule

bind qdac_frontend qdac_checker #(
  .CODE_W(CODE_W), .CHANNELS(CHANNELS), .SYNC_STAGES(SYNC_STAGES)
) u_chk (.*);

// File: tb/tb_qdac_frontend.sv
module tb_qdac_frontend;
  localparam time CLK_PERIOD = 10ns;
  localparam int  SETTLE = 6;

  logic clk = 1'b0;
  logic resetN = 1'b0, resetSel = 1'b0;
  logic csN = 1'b1, sclk = 1'b1, sdi = 1'b0;
  logic loadRegN = 1'b1, ldacN = 1'b1;
  logic [47:0] dacCode;
  logic updateStrobe;

  int checks = 0, errors = 0, strobeCount = 0;
  bit finished = 0;
  logic [15:0] mdl = '0;
  logic [11:0] expIn [4];
  logic [11:0] expDac [4];

  qdac_frontend dut (
    .clk(clk), .resetN(resetN), .resetSel(resetSel), .csN(csN), .sclk(sclk),
    .sdi(sdi), .loadRegN(loadRegN), .ldacN(ldacN), .dacCode(dacCode),
    .updateStrobe(updateStrobe)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) if (updateStrobe) strobeCount++;

  task automatic checkVal(string req, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, got, exp);
    end
  endtask

  task automatic checkCodes(string req);
    for (int c = 0; c < 4; c++)
      checkVal(req, int'(dacCode[c*12 +: 12]), int'(expDac[c]));
  endtask

  // apply the open-register rules to the model (R4, R5, R9)
  task automatic settle();
    if (!loadRegN) expIn[mdl[15:14]] = mdl[11:0];
    if (!ldacN) for (int c = 0; c < 4; c++) expDac[c] = expIn[c];
  endtask

  task automatic drive(logic cs, logic sc, logic sd, logic lr, logic ld);
    logic oldOr, newOr;
    @(negedge clk);
    oldOr = csN | sclk;
    newOr = cs | sc;
    csN = cs; sclk = sc; sdi = sd; loadRegN = lr; ldacN = ld;
    repeat (SETTLE) @(negedge clk);
    if (newOr && !oldOr) mdl = {mdl[14:0], sd};
    settle();
  endtask

  task automatic sendWord(logic [1:0] addr, logic [1:0] pad, logic [11:0] code,
                          bit extra, logic lr);
    logic [15:0] w;
    w = {addr, pad, code};
    drive(1'b0, 1'b1, sdi, lr, ldacN);
    for (int i = 15; i >= 0; i--) begin
      drive(1'b0, 1'b0, w[i], lr, ldacN);
      drive(1'b0, 1'b1, w[i], lr, ldacN);
    end
    if (extra) begin
      drive(1'b0, 1'b0, w[0], lr, ldacN);
      drive(1'b1, 1'b0, w[0], lr, ldacN);
    end
    drive(1'b1, 1'b1, w[0], lr, ldacN);
  endtask

  task automatic loadPulse();
    drive(csN, sclk, sdi, 1'b0, ldacN);
    drive(csN, sclk, sdi, 1'b1, ldacN);
  endtask

  task automatic ldacPulse(string req);
    int expStrobe;
    expStrobe = 0;
    for (int c = 0; c < 4; c++) if (expIn[c] != expDac[c]) expStrobe = 1;
    strobeCount = 0;
    drive(csN, sclk, sdi, loadRegN, 1'b0);
    drive(csN, sclk, sdi, loadRegN, 1'b1);
    checkVal({req, " R10 strobe count"}, strobeCount, expStrobe);
    checkCodes(req);
  endtask

  task automatic doReset(logic sel, bit lrLow);
    logic [11:0] rc;
    rc = sel ? 12'h800 : 12'h000;
    @(negedge clk); resetSel = sel;
    @(negedge clk); resetN = 1'b0;
    for (int c = 0; c < 4; c++) begin expIn[c] = rc; expDac[c] = rc; end
    if (lrLow) loadRegN = 1'b0;
    strobeCount = 0;
    repeat (3) @(negedge clk);
    checkCodes("R6 forced code");
    checkVal("R10 quiet in reset", strobeCount, 0);
    resetN = 1'b1;
    repeat (SETTLE) @(negedge clk);
    settle();
    checkCodes("R8 keeps reset code");
    if (lrLow) begin
      loadRegN = 1'b1;
      repeat (SETTLE) @(negedge clk);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [11:0] code;
    for (int c = 0; c < 4; c++) begin expIn[c] = '0; expDac[c] = '0; end
    repeat (4) @(negedge clk);
    checkCodes("R6 zero-scale at start");
    checkVal("R10 quiet at start", int'(updateStrobe), 0);
    resetN = 1'b1;
    repeat (SETTLE) @(negedge clk);
    checkCodes("R8 after first release");

    doReset(1'b1, 1'b0);   // mid-scale

    // sweep: stage four channels, then transfer together (R1 R4 R5 R10)
    for (int r = 0; r < 6; r++) begin
      for (int ch = 0; ch < 4; ch++) begin
        if (r == 0)      code = 12'h000;
        else if (r == 1) code = 12'hFFF;
        else             code = 12'((r * 977 + ch * 331 + 5) % 4096);
        sendWord(2'(ch), 2'(r), code, 1'b0, 1'b1);
        loadPulse();
        checkCodes("R4 load alone holds outputs");
      end
      ldacPulse("R1 R5 transfer");
    end
    ldacPulse("R10 transfer without change");

    // R2: clock toggles with select high do nothing
    for (int i = 0; i < 8; i++) drive(1'b1, 1'(i % 2), 1'(i % 3 == 0), 1'b1, 1'b1);
    drive(1'b1, 1'b1, 1'b0, 1'b1, 1'b1);
    loadPulse();
    ldacPulse("R2 select high blocks shift");

    // R3: select rises while clock is low
    sendWord(2'd1, 2'd0, 12'h5A3, 1'b1, 1'b1);
    loadPulse();
    ldacPulse("R3 extra shift");
    sendWord(2'd2, 2'd3, 12'h2C7, 1'b1, 1'b1);
    loadPulse();
    ldacPulse("R3 extra shift second");

    // R5: transfer pin held low, load goes straight through
    drive(1'b1, 1'b1, 1'b0, 1'b1, 1'b0);
    sendWord(2'd3, 2'd1, 12'h9E1, 1'b0, 1'b1);
    loadPulse();
    checkCodes("R5 transparent transfer");
    drive(1'b1, 1'b1, 1'b0, 1'b1, 1'b1);

    // R9: shifting with load and transfer open
    drive(1'b1, 1'b1, 1'b0, 1'b1, 1'b0);
    sendWord(2'd1, 2'd2, 12'hB4D, 1'b0, 1'b0);
    checkCodes("R9 corruption during shift");
    drive(1'b1, 1'b1, 1'b0, 1'b1, 1'b1);
    ldacPulse("R9 after corruption");

    // R7: reset leaves the shifted word intact
    sendWord(2'd3, 2'd0, 12'h6F0, 1'b0, 1'b1);
    doReset(1'b0, 1'b0);
    loadPulse();
    ldacPulse("R7 word survives reset");

    // R8: release with load open
    sendWord(2'd0, 2'd1, 12'h3A5, 1'b0, 1'b1);
    doReset(1'b1, 1'b1);
    ldacPulse("R8 open register at release");

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule